// File: doc/BRIEF.md
# Configurable UTOPIA receive cell interface

This block sits on the PHY side of an ATM receive path. Upstream logic writes each cell into a small on-chip buffer, one octet per cycle. A cell is always stored as 52 octets: four header octets and then 48 payload octets. An ATM-layer reader then pulls the cell out over a UTOPIA-style data bus. That bus runs either one octet or two octets per transfer.

On the way out, the block can place a header check octet after the header. In two-octet mode that check octet is paired with a zero stuff octet, so the cell fills a whole number of words. The first transfer of every cell carries a start-of-cell marker. A transfer counter makes each cell exactly as long as the configuration selects. A read made when no cell is waiting returns zero and raises an invalid-read flag. Such a read does not move any pointer.

Bus width and cell size sit together in one configuration byte. The configuration register is seen at address 0x6A. The block captures both settings at the start of each cell, so software may change them at any time without tearing a cell apart. The header check value is a fixed filler octet, set by the parameter `HEC_FILL` (default 0x5A).

Top module: `urx_cell_rx`

## Requirements
- R1: The configuration register answers only at address 0x6A. After reset it reads 0x00. Bits 6:0 read back what was last written, and bit 7 always reads 0. Bit 0 set to 1 selects the 16-bit bus, and bit 3 set to 1 selects 52-octet cells.
- R2: With bit 0 = 0 and bit 3 = 1, a cell takes 52 transfers. Transfer k carries buffered octet k in rd_data[7:0], and rd_data[15:8] is 0.
- R3: With bit 0 = 0 and bit 3 = 0, a cell takes 53 transfers. Transfers 0 to 3 carry octets 0 to 3. Transfer 4 carries HEC_FILL. Transfer k, for k of 5 or more, carries octet k-1. rd_data[15:8] is 0.
- R4: With bit 0 = 1 and bit 3 = 1, a cell takes 26 words. Word w carries octet 2w in rd_data[15:8] and octet 2w+1 in rd_data[7:0].
- R5: With bit 0 = 1 and bit 3 = 0, a cell takes 27 words. Words 0 and 1 carry octets 0 to 3, with the upper byte first. Word 2 is {HEC_FILL, 8'h00}. Word w, for w of 3 or more, carries octets 2w-2 and 2w-1.
- R6: A read sampled on a rising edge updates rd_data on that edge. rd_soc is high for exactly the first transfer of each cell.
- R7: A read sampled when no cell is in progress and none is buffered sets rd_invalid and drives rd_data to 0. It consumes nothing, so the next cell starts at its transfer 0 with rd_soc.
- R8: A change to bit 0 or bit 3 made in the middle of a cell leaves that cell in its old format. The change applies from the next cell.
- R9: The buffer holds CELLS complete cells (default 2). in_ready is low while all of them are filled, and octets offered then are dropped. cell_avail is high while at least one complete cell is stored.
- R10: In a cycle after rd_en was low, rd_soc and rd_invalid are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration register contents |
| in_valid | input | 1 | Upstream octet valid |
| in_octet | input | 8 | Upstream cell octet |
| in_ready | output | 1 | Buffer can accept an octet |
| cell_avail | output | 1 | At least one complete cell stored |
| rd_en | input | 1 | Reader takes one transfer this cycle |
| rd_data | output | 16 | Transfer data; upper byte is zero in 8-bit mode |
| rd_soc | output | 1 | First transfer of a cell |
| rd_invalid | output | 1 | Read made with no cell available |

## Verification
All four width and size combinations are run with two cells, and each cell carries its own octet pattern. A shifted octet, a misplaced check or stuff octet, or a wrong cell length therefore shows up in a specific word. Back-to-back cells show whether the start marker and the octet index restart correctly. A read after the last buffered cell separates the invalid-read path from a read that runs over into the next cell. A configuration change in the middle of a cell, followed by a further cell, shows whether the new setting is captured only at the cell boundary. Octets offered while the buffer is full must leave the stored cells intact.

// File: rtl/urx_pkg.sv
package urx_pkg;
  // Octets held per stored cell (header plus payload, no check octet)
  localparam int OCTETS_PER_CELL = 52;
  localparam int IDX_W = 6;

  localparam logic [IDX_W-1:0] LAST_OCT    = IDX_W'(OCTETS_PER_CELL - 1);
  localparam logic [IDX_W-1:0] HEC_SLOT8   = IDX_W'(4);
  localparam logic [IDX_W-1:0] HEC_SLOT16  = IDX_W'(2);
  localparam logic [IDX_W-1:0] LAST_8_52   = IDX_W'(51);
  localparam logic [IDX_W-1:0] LAST_8_53   = IDX_W'(52);
  localparam logic [IDX_W-1:0] LAST_16_52  = IDX_W'(25);
  localparam logic [IDX_W-1:0] LAST_16_54  = IDX_W'(26);

  typedef enum logic [1:0] {SRC_MEM, SRC_HEC, SRC_ZERO} src_e;

  typedef struct packed {
    logic w16;   // two-octet bus
    logic s52;   // 52-octet cells, no check octet
  } fmt_t;

  function automatic logic [IDX_W-1:0] last_index(fmt_t f);
    case ({f.w16, f.s52})
      2'b00:   return LAST_8_53;
      2'b01:   return LAST_8_52;
      2'b10:   return LAST_16_54;
      default: return LAST_16_52;
    endcase
  endfunction
endpackage

// File: rtl/urx_cfg_reg.sv
module urx_cfg_reg #(
  parameter logic [7:0] REG_ADDR = 8'h6A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [7:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output urx_pkg::fmt_t     fmt
);
  logic [6:0] bits_q, bits_d;
  logic       hit;

  assign hit = wr && (addr == REG_ADDR);

  always_comb begin
    bits_d = bits_q;
    if (hit) bits_d = wdata[6:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= bits_d;
  end

  assign rdata    = {1'b0, bits_q};
  assign fmt.w16  = bits_q[0];
  assign fmt.s52  = bits_q[3];

  // R1
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(rdata));
endmodule

// File: rtl/urx_word_map.sv
module urx_word_map
  import urx_pkg::*;
(
  input  fmt_t             fmt,
  input  logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] addr_hi,
  output logic [IDX_W-1:0] addr_lo,
  output src_e             src_hi,
  output src_e             src_lo,
  output logic [IDX_W-1:0] last
);
  logic [IDX_W-1:0] dbl;
  assign dbl  = {idx[IDX_W-2:0], 1'b0};
  assign last = last_index(fmt);

  always_comb begin
    addr_hi = '0;
    addr_lo = '0;
    src_hi  = SRC_ZERO;
    src_lo  = SRC_MEM;
    if (!fmt.w16) begin
      if (!fmt.s52 && idx == HEC_SLOT8)     src_lo  = SRC_HEC;
      else if (!fmt.s52 && idx > HEC_SLOT8) addr_lo = idx - IDX_W'(1);
      else                                  addr_lo = idx;
    end else begin
      src_hi = SRC_MEM;
      if (!fmt.s52 && idx == HEC_SLOT16) begin
        src_hi = SRC_HEC;
        src_lo = SRC_ZERO;
      end else if (!fmt.s52 && idx > HEC_SLOT16) begin
        addr_hi = dbl - IDX_W'(2);
        addr_lo = dbl - IDX_W'(1);
      end else begin
        addr_hi = dbl;
        addr_lo = dbl + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/urx_cell_buf.sv
module urx_cell_buf
  import urx_pkg::*;
#(
  parameter int CELLS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_octet,
  output logic             in_ready,
  input  logic [IDX_W-1:0] rd_addr_hi,
  input  logic [IDX_W-1:0] rd_addr_lo,
  output logic [7:0]       rd_hi,
  output logic [7:0]       rd_lo,
  input  logic             release_cell,
  output logic             avail
);
  localparam int DEPTH = CELLS * OCTETS_PER_CELL;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = (CELLS > 1) ? $clog2(CELLS) : 1;
  localparam int NW    = $clog2(CELLS + 1);
  localparam logic [CW-1:0] CELL_TOP = CW'(CELLS - 1);
  localparam logic [NW-1:0] CNT_FULL = NW'(CELLS);

  logic [7:0]       mem [DEPTH];
  logic [IDX_W-1:0] wr_oct_q, wr_oct_d;
  logic [CW-1:0]    wr_cell_q, wr_cell_d, rd_cell_q, rd_cell_d;
  logic [NW-1:0]    cnt_q, cnt_d;
  logic             wr_fire, cell_done;
  logic [AW-1:0]    wa, ra_hi, ra_lo;

  assign in_ready  = (cnt_q != CNT_FULL);
  assign avail     = (cnt_q != '0);
  assign wr_fire   = in_valid && in_ready;
  assign cell_done = wr_fire && (wr_oct_q == LAST_OCT);

  assign wa    = AW'(wr_cell_q) * AW'(OCTETS_PER_CELL) + AW'(wr_oct_q);
  assign ra_hi = AW'(rd_cell_q) * AW'(OCTETS_PER_CELL) + AW'(rd_addr_hi);
  assign ra_lo = AW'(rd_cell_q) * AW'(OCTETS_PER_CELL) + AW'(rd_addr_lo);
  assign rd_hi = mem[ra_hi];
  assign rd_lo = mem[ra_lo];

  always_comb begin
    wr_oct_d  = wr_oct_q;
    wr_cell_d = wr_cell_q;
    rd_cell_d = rd_cell_q;
    cnt_d     = cnt_q;
    if (wr_fire) wr_oct_d = cell_done ? '0 : wr_oct_q + IDX_W'(1);
    if (cell_done) wr_cell_d = (wr_cell_q == CELL_TOP) ? '0 : wr_cell_q + CW'(1);
    if (release_cell) rd_cell_d = (rd_cell_q == CELL_TOP) ? '0 : rd_cell_q + CW'(1);
    if (cell_done && !release_cell)      cnt_d = cnt_q + NW'(1);
    else if (!cell_done && release_cell) cnt_d = cnt_q - NW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_oct_q  <= '0;
      wr_cell_q <= '0;
      rd_cell_q <= '0;
      cnt_q     <= '0;
    end else begin
      wr_oct_q  <= wr_oct_d;
      wr_cell_q <= wr_cell_d;
      rd_cell_q <= rd_cell_d;
      cnt_q     <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wa] <= in_octet;
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
  // R9
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_FULL) |=> $stable(wr_oct_q));
  // R7
  release_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_cell |-> avail);
endmodule

// File: rtl/urx_cell_rx.sv
module urx_cell_rx
  import urx_pkg::*;
#(
  parameter int         CELLS    = 2,
  parameter logic [7:0] CFG_ADDR = 8'h6A,
  parameter logic [7:0] HEC_FILL = 8'h5A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_addr,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_rdata,
  input  logic        in_valid,
  input  logic [7:0]  in_octet,
  output logic        in_ready,
  output logic        cell_avail,
  input  logic        rd_en,
  output logic [15:0] rd_data,
  output logic        rd_soc,
  output logic        rd_invalid
);
  logic [1:0]       rst_pipe;
  logic             rst_n_s;
  fmt_t             cfg_fmt, act_q, act_d, eff;
  logic [IDX_W-1:0] idx_q, idx_d, addr_hi, addr_lo, last;
  src_e             src_hi, src_lo;
  logic [7:0]       mem_hi, mem_lo, byte_hi, byte_lo;
  logic [15:0]      data_d;
  logic             soc_d, inv_d, rel, can_read, avail;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  urx_cfg_reg #(.REG_ADDR(CFG_ADDR)) cfg_i (
    .clk(clk), .rst_n(rst_n_s), .wr(cfg_wr), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .fmt(cfg_fmt));

  // format is taken from the register only between cells
  assign eff = (idx_q == '0) ? cfg_fmt : act_q;

  urx_word_map map_i (
    .fmt(eff), .idx(idx_q), .addr_hi(addr_hi), .addr_lo(addr_lo),
    .src_hi(src_hi), .src_lo(src_lo), .last(last));

  urx_cell_buf #(.CELLS(CELLS)) buf_i (
    .clk(clk), .rst_n(rst_n_s), .in_valid(in_valid), .in_octet(in_octet),
    .in_ready(in_ready), .rd_addr_hi(addr_hi), .rd_addr_lo(addr_lo),
    .rd_hi(mem_hi), .rd_lo(mem_lo), .release_cell(rel), .avail(avail));

  assign cell_avail = avail;
  assign can_read   = (idx_q != '0) || avail;

  always_comb begin
    case (src_hi)
      SRC_MEM: byte_hi = mem_hi;
      SRC_HEC: byte_hi = HEC_FILL;
      default: byte_hi = 8'h00;
    endcase
    case (src_lo)
      SRC_MEM: byte_lo = mem_lo;
      SRC_HEC: byte_lo = HEC_FILL;
      default: byte_lo = 8'h00;
    endcase
  end

  always_comb begin
    data_d = rd_data;
    soc_d  = 1'b0;
    inv_d  = 1'b0;
    idx_d  = idx_q;
    act_d  = eff;
    rel    = 1'b0;
    if (rd_en) begin
      if (can_read) begin
        data_d = {byte_hi, byte_lo};
        soc_d  = (idx_q == '0);
        if (idx_q == last) begin
          idx_d = '0;
          rel   = 1'b1;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end else begin
        data_d = '0;
        inv_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      idx_q      <= '0;
      act_q      <= '0;
      rd_data    <= '0;
      rd_soc     <= 1'b0;
      rd_invalid <= 1'b0;
    end else begin
      idx_q      <= idx_d;
      act_q      <= act_d;
      rd_data    <= data_d;
      rd_soc     <= soc_d;
      rd_invalid <= inv_d;
    end
  end

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !rd_en |=> (!rd_soc && !rd_invalid));
  // R7
  invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_invalid |-> (rd_data == 16'h0000 && !rd_soc));
  // R7
  invalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_en && idx_q == '0 && !cell_avail) |=> $stable(idx_q));
  // R8
  mid_cell_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (idx_q != '0) |=> $stable(act_q));
  // R6
  soc_start_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_soc |-> (idx_q == '0 || idx_q == IDX_W'(1)));
endmodule

// File: tb/urx_cell_rx_tb_top.sv
module urx_cell_rx_tb_top;
  localparam logic [7:0] HEC = 8'h5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic        in_valid = 1'b0;
  logic [7:0]  in_octet = 8'h00;
  logic        in_ready, cell_avail;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        rd_soc, rd_invalid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  urx_cell_rx dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
    .in_octet(in_octet), .in_ready(in_ready), .cell_avail(cell_avail),
    .rd_en(rd_en), .rd_data(rd_data), .rd_soc(rd_soc), .rd_invalid(rd_invalid));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'((seed * 37 + k * 5 + 1) & 255);
  endfunction

  function automatic logic [15:0] exp_word(input int seed, input bit w16, input bit s52, input int w);
    int o;
    if (!w16) begin
      if (!s52 && w == 4) return {8'h00, HEC};
      o = (!s52 && w > 4) ? w - 1 : w;
      return {8'h00, pat(seed, o)};
    end
    if (!s52 && w == 2) return {HEC, 8'h00};
    o = (!s52 && w > 2) ? 2 * w - 2 : 2 * w;
    return {pat(seed, o), pat(seed, o + 1)};
  endfunction

  function automatic int words(input bit w16, input bit s52);
    if (s52) return w16 ? 26 : 52;
    return w16 ? 27 : 53;
  endfunction

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic push_cell(input int seed);
    for (int k = 0; k < 52; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_octet = pat(seed, k);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic read_words(input int seed, input bit w16, input bit s52,
                            input int from, input int upto, input string req);
    for (int w = from; w < upto; w++) begin
      rd_en = 1'b1;
      @(negedge clk);
      check(req, 32'(rd_data), 32'(exp_word(seed, w16, s52, w)));
      check({req, "/R6 soc"}, 32'(rd_soc), 32'(w == 0));
    end
    rd_en = 1'b0;
  endtask

  task automatic invalid_read(input string req);
    rd_en = 1'b1;
    @(negedge clk);
    check({req, " invalid"}, 32'(rd_invalid), 32'd1);
    check({req, " data"}, 32'(rd_data), 32'd0);
    rd_en = 1'b0;
    @(negedge clk);
    check("R10 quiet", 32'({rd_soc, rd_invalid}), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    check("R1 reset", 32'(cfg_rdata), 32'h00);
    check("R9 ready", 32'({in_ready, cell_avail}), 32'b10);
    check("R10 reset", 32'({rd_soc, rd_invalid}), 32'd0);

    // R1 register access
    cfg_write(8'h6A, 8'hFF);
    check("R1 rw", 32'(cfg_rdata), 32'h7F);
    cfg_write(8'h6B, 8'h00);
    check("R1 addr", 32'(cfg_rdata), 32'h7F);
    cfg_write(8'h6A, 8'h00);
    check("R1 clear", 32'(cfg_rdata), 32'h00);

    // R7 empty read
    @(negedge clk);
    invalid_read("R7 empty");

    // sweep of all four formats, two cells each
    for (int c = 0; c < 4; c++) begin
      bit w16, s52;
      w16 = c[0]; s52 = c[1];
      case (c)
        0: tag = "R3";
        1: tag = "R5";
        2: tag = "R2";
        default: tag = "R4";
      endcase
      cfg_write(8'h6A, {4'b0, s52, 2'b0, w16});
      push_cell(10 + c);
      push_cell(20 + c);
      check("R9 full", 32'({in_ready, cell_avail}), 32'b01);
      if (c == 0) begin
        // octets offered while full must be dropped
        @(negedge clk); in_valid = 1'b1; in_octet = 8'hEE;
        @(negedge clk); in_valid = 1'b0;
      end
      @(negedge clk);
      read_words(10 + c, w16, s52, 0, words(w16, s52), tag);
      check("R9 one left", 32'({in_ready, cell_avail}), 32'b11);
      read_words(20 + c, w16, s52, 0, words(w16, s52), tag);
      check("R9 empty", 32'(cell_avail), 32'd0);
      invalid_read("R7 past end");
    end

    // R8 format change in mid-cell
    cfg_write(8'h6A, 8'h00);
    push_cell(40);
    push_cell(41);
    @(negedge clk);
    read_words(40, 1'b0, 1'b0, 0, 10, "R8 before");
    cfg_write(8'h6A, 8'h09);
    read_words(40, 1'b0, 1'b0, 10, 53, "R8 old fmt");
    read_words(41, 1'b1, 1'b1, 0, 26, "R8 new fmt");
    invalid_read("R7 after R8");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule